// File: doc/BRIEF.md
# Byte-Selectable Latched-Address Static RAM

This block is a clocked model of a static RAM whose 18-bit word is made of two 9-bit byte lanes. Bits 17:9 form the high lane and bits 8:0 the low lane. A ninth bit per lane is free to carry byte parity, but the block does not generate or check parity. The controls are active low: chip enable, write enable, output enable and one select per lane. A deselected part reports standby and ignores every access.

An address latch sits in front of the array. While the latch-enable input is high the address flows straight through. The same clock edge also records it, so the held value is used once latch enable drops. A system that changes only the address with latch enable high gets a new read word each time, with no other strobe.

The shared data bus is split into a data-in port, a data-out port and one drive-enable bit per lane. A lane that is not driven presents zero. Writes land on the rising clock edge. The parameter `READ_REG` chooses when read data appears: in the same cycle, straight from the effective address, or one clock later through a register stage.

Top module: `lat_sram`

## Requirements
- R1: With chip enable, write enable and both selects low, the rising edge stores the whole 18-bit data-in word at the effective address. A later read with both selects and output enable low returns that word on both lanes.
- R2: A write with only one select low updates only that lane. The high lane is bits 17:9 and the low lane is bits 8:0. The other lane keeps its earlier contents.
- R3: During a read, a lane's drive-enable bit is set only if that lane's select is low. Bit 1 is the high lane and bit 0 the low lane. An undriven lane shows zero on data-out.
- R4: With output enable high, no lane is driven, even while a read is selected.
- R5: While write enable is low, no lane is driven, even with output enable low.
- R6: With chip enable high, standby is 1, nothing is written and no lane is driven. With chip enable low, standby is 0.
- R7: With latch enable high, the address input is used directly, so each new address gives its own read word with no further strobe.
- R8: While latch enable is low, reads and writes use the address sampled at the last rising edge at which latch enable was high.
- R9: With `READ_REG`=0, read data and drive enables follow the inputs in the same cycle. With `READ_REG`=1, they follow the inputs present at the previous rising edge, and they are 0 after reset.
- R10: With chip enable low but both selects high, no write happens and no lane is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and the latch update on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the latch and the read stage |
| addrIn | input | ADDR_W | Word address |
| aleHi | input | 1 | Latch enable: 1 passes the address through, 0 holds it |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| selHiN | input | 1 | High-lane select (bits 17:9), active low |
| selLoN | input | 1 | Low-lane select (bits 8:0), active low |
| dIn | input | 2*BYTE_W | Write data |
| dOut | output | 2*BYTE_W | Read data; zero in undriven lanes |
| dOutEn | output | 2 | Per-lane drive enable; bit 1 high lane, bit 0 low lane |
| standby | output | 1 | High while the chip is deselected |

## Verification
Two instances with a 32-word array run side by side, one combinational and one registered, and both are compared against a reference array lane by lane. The stimulus includes byte writes that overlay different patterns on each lane of every word. A design that writes the whole word on a byte write would wipe the other lane, and a design that drives a lane whose select is high would put stale data on it. Writes are issued with output enable low, with chip enable high, and with both selects high. A design that drives the bus during a write, or that writes while deselected, is caught either on the enables or when the word is read back. A latch sequence changes the address after latch enable drops, and a write is made through a held address. A transparent-only latch would read or write the wrong word. The registered instance is also sampled before its edge, which exposes a read stage that leaks the current inputs.

// File: rtl/lat_sram_pkg.sv
package lat_sram_pkg;
  // Per-lane strobes from control to datapath; index 1 = high lane, 0 = low lane
  typedef struct packed {
    logic [1:0] wrLane;
    logic [1:0] rdLane;
    logic [1:0] drvLane;
    logic       standby;
  } ctrlStrobe_t;

  localparam int LANES = 2;
endpackage

// File: rtl/lat_sram_ctrl.sv
module lat_sram_ctrl
  import lat_sram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        weN,
  input  logic        oeN,
  input  logic        selHiN,
  input  logic        selLoN,
  output ctrlStrobe_t strb
);
  logic       chipOn;
  logic       isWrite;
  logic [1:0] laneSel;

  assign chipOn  = ~ceN;
  assign isWrite = chipOn & ~weN;
  assign laneSel = {~selHiN, ~selLoN};

  always_comb begin
    strb         = '0;
    strb.standby = ~chipOn;
    for (int i = 0; i < LANES; i++) begin
      strb.wrLane[i]  = isWrite & laneSel[i];
      strb.rdLane[i]  = chipOn & weN & laneSel[i];
      strb.drvLane[i] = strb.rdLane[i] & ~oeN;
    end
  end

  // R6
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (strb.wrLane == 2'b00 && strb.drvLane == 2'b00 && strb.standby));

  // R10
  no_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selHiN && selLoN) |-> (strb.wrLane == 2'b00 && strb.rdLane == 2'b00));
endmodule

// File: rtl/lat_sram_dp.sv
module lat_sram_dp
  import lat_sram_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int BYTE_W   = 9,
  parameter bit READ_REG = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic                  aleHi,
  input  logic [2*BYTE_W-1:0]   dIn,
  input  ctrlStrobe_t           strb,
  output logic [2*BYTE_W-1:0]   dOut,
  output logic [1:0]            dOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] heldAddr;
  logic [ADDR_W-1:0] effAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      heldAddr <= '0;
    else if (aleHi) heldAddr <= addrIn;
  end

  assign effAddr = aleHi ? addrIn : heldAddr;

  // R8
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aleHi) |-> (effAddr == $past(addrIn)));

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!aleHi && !$past(aleHi)) |-> $stable(effAddr));

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BYTE_W-1:0] laneMem [DEPTH];
    logic [BYTE_W-1:0] laneRd;

    always_ff @(posedge clk) begin
      if (strb.wrLane[g]) laneMem[effAddr] <= dIn[g*BYTE_W +: BYTE_W];
    end

    assign laneRd = laneMem[effAddr];

    if (READ_REG) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dOutEn[g]                 <= 1'b0;
          dOut[g*BYTE_W +: BYTE_W]  <= '0;
        end else begin
          dOutEn[g]                 <= strb.drvLane[g];
          dOut[g*BYTE_W +: BYTE_W]  <= strb.drvLane[g] ? laneRd : '0;
        end
      end

      // R5
      write_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrLane[g] |=> !dOutEn[g]);
    end else begin : gComb
      assign dOutEn[g]                = strb.drvLane[g];
      assign dOut[g*BYTE_W +: BYTE_W] = strb.drvLane[g] ? laneRd : '0;

      // R5
      write_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrLane[g] |-> !dOutEn[g]);
    end

    // R3
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      !dOutEn[g] |-> (dOut[g*BYTE_W +: BYTE_W] == '0));
  end
endmodule

// File: rtl/lat_sram.sv
module lat_sram
  import lat_sram_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int BYTE_W   = 9,
  parameter bit READ_REG = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                aleHi,
  input  logic                ceN,
  input  logic                weN,
  input  logic                oeN,
  input  logic                selHiN,
  input  logic                selLoN,
  input  logic [2*BYTE_W-1:0] dIn,
  output logic [2*BYTE_W-1:0] dOut,
  output logic [1:0]          dOutEn,
  output logic                standby
);
  ctrlStrobe_t strb;

  lat_sram_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .selHiN(selHiN), .selLoN(selLoN), .strb(strb)
  );

  lat_sram_dp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .READ_REG(READ_REG)) dp_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .aleHi(aleHi), .dIn(dIn),
    .strb(strb), .dOut(dOut), .dOutEn(dOutEn)
  );

  assign standby = strb.standby;

  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (READ_REG || dOutEn == 2'b00));
endmodule

// File: tb/lat_sram_tb_top.sv
module lat_sram_tb_top;
  localparam int AW = 5;
  localparam int BW = 9;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, aleHi, ceN, weN, oeN, selHiN, selLoN;
  logic [AW-1:0] addr;
  logic [17:0]   dIn;
  logic [17:0]   dOutC, dOutR;
  logic [1:0]    enC, enR;
  logic          sbC, sbR;

  lat_sram #(.ADDR_W(AW), .BYTE_W(BW), .READ_REG(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addr), .aleHi(aleHi), .ceN(ceN), .weN(weN),
    .oeN(oeN), .selHiN(selHiN), .selLoN(selLoN), .dIn(dIn),
    .dOut(dOutC), .dOutEn(enC), .standby(sbC));

  lat_sram #(.ADDR_W(AW), .BYTE_W(BW), .READ_REG(1'b1)) dutReg_i (
    .clk(clk), .rstN(rstN), .addrIn(addr), .aleHi(aleHi), .ceN(ceN), .weN(weN),
    .oeN(oeN), .selHiN(selHiN), .selLoN(selLoN), .dIn(dIn),
    .dOut(dOutR), .dOutEn(enR), .standby(sbR));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [17:0] refMem [N];

  task automatic check(string req, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic ale, logic [AW-1:0] a, logic ce, logic we, logic oe,
                       logic hi, logic lo, logic [17:0] d);
    @(negedge clk);
    aleHi = ale; addr = a; ceN = ce; weN = we; oeN = oe;
    selHiN = hi; selLoN = lo; dIn = d;
  endtask

  function automatic logic [17:0] patA(int a);
    return 18'((a * 2731 + 77) & 18'h3FFFF);
  endfunction
  function automatic logic [17:0] patB(int a);
    return 18'((a * 9029 + 40503) & 18'h3FFFF);
  endfunction

  // R1 R2 R5: write through a transparent latch, never driving the bus
  task automatic wr(string req, int a, logic hi, logic lo, logic [17:0] d);
    drive(1'b1, AW'(a), 1'b0, 1'b0, 1'b0, hi, lo, d);
    #1 check({req, "/R5"}, {enC, 18'h0}, 20'h0);
    @(posedge clk);
    #1 check({req, "/R5"}, {enR, 18'h0}, 20'h0);
    if (!hi) refMem[a][17:9] = d[17:9];
    if (!lo) refMem[a][8:0]  = d[8:0];
  endtask

  function automatic logic [19:0] expRd(int a, logic hi, logic lo, logic oe);
    logic [1:0]  en;
    logic [17:0] v;
    en = {~hi & ~oe, ~lo & ~oe};
    v  = {en[1] ? refMem[a][17:9] : 9'h0, en[0] ? refMem[a][8:0] : 9'h0};
    return {en, v};
  endfunction

  task automatic rd(string req, int a, logic hi, logic lo, logic oe);
    logic [19:0] e;
    e = expRd(a, hi, lo, oe);
    drive(1'b1, AW'(a), 1'b0, 1'b1, oe, hi, lo, 18'h0);
    #1 check(req, {enC, dOutC}, e);
    check({req, "/R6"}, {19'h0, sbC}, 20'h0);
    @(posedge clk);
    #1 check({req, "/R9"}, {enR, dOutR}, e);
  endtask

  initial begin
    rstN = 1'b0; aleHi = 1'b1; addr = '0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    selHiN = 1'b1; selLoN = 1'b1; dIn = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9 / R6: reset state
    check("R9 reset", {enR, dOutR}, 20'h0);
    check("R6 reset", {enC, sbC, sbR, dOutC[15:0]}, {2'b00, 2'b11, 16'h0});
    @(negedge clk) rstN = 1'b1;

    // R1 and R7: full words, address swept with latch open
    for (int a = 0; a < N; a++) wr("R1", a, 1'b0, 1'b0, patA(a));
    for (int a = 0; a < N; a++) rd("R7", a, 1'b0, 1'b0, 1'b0);

    // R2: overlay each lane separately
    for (int a = 0; a < N; a++) wr("R2", a, 1'b0, 1'b1, patB(a));
    for (int a = 0; a < N; a++) rd("R2", a, 1'b0, 1'b0, 1'b0);
    for (int a = 0; a < N; a += 2) wr("R2", a, 1'b1, 1'b0, ~patB(a));
    for (int a = 0; a < N; a++) rd("R2", a, 1'b0, 1'b0, 1'b0);

    // R3: single-lane reads
    for (int a = 0; a < N; a++) begin
      rd("R3", a, 1'b0, 1'b1, 1'b0);
      rd("R3", a, 1'b1, 1'b0, 1'b0);
    end

    // R4: output enable high
    for (int a = 0; a < 4; a++) rd("R4", a, 1'b0, 1'b0, 1'b1);

    // R9: registered outputs lag the inputs by one edge
    rd("R9", 5, 1'b0, 1'b0, 1'b0);
    drive(1'b1, AW'(6), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'h0);
    #1 check("R9 lag", {enR, dOutR}, expRd(5, 1'b0, 1'b0, 1'b0));
    check("R9 same", {enC, dOutC}, 20'h0);

    // R10: both selects high, write attempt ignored
    drive(1'b1, AW'(3), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 18'h2AAAA);
    #1 check("R10", {enC, 18'h0}, 20'h0);
    @(posedge clk);
    #1 check("R10", {enR, 18'h0}, 20'h0);
    rd("R10", 3, 1'b0, 1'b0, 1'b0);

    // R6: deselected write attempt
    drive(1'b1, AW'(4), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'h15555);
    #1 check("R6", {enC, sbC, sbR, 16'h0}, {2'b00, 2'b11, 16'h0});
    @(posedge clk);
    #1 check("R6", {enR, 18'h0}, 20'h0);
    rd("R6", 4, 1'b0, 1'b0, 1'b0);

    // R8: address held after latch enable drops
    drive(1'b1, AW'(9), 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 18'h0);
    drive(1'b0, AW'(20), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 18'h0);
    #1 check("R8 read", {enC, dOutC}, expRd(9, 1'b0, 1'b0, 1'b0));
    @(posedge clk);
    #1 check("R8 read", {enR, dOutR}, expRd(9, 1'b0, 1'b0, 1'b0));
    drive(1'b0, AW'(21), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h3C3C3);
    @(posedge clk);
    refMem[9] = 18'h3C3C3;
    rd("R8 write", 9, 1'b0, 1'b0, 1'b0);
    rd("R8 other", 21, 1'b0, 1'b0, 1'b0);
    rd("R8 other", 20, 1'b0, 1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule